// File: doc/BRIEF.md
# Serial ADC Channel Scan Controller

This block sits on the host side of a 12-bit, 8-input serial analog-to-digital converter and keeps it converting over a chosen set of inputs. Each transfer is a 16-clock serial frame framed by an active-low select. During the first half of the frame the controller sends an 8-bit command word, and during the whole frame it collects the converter's reply. The command carries the input to convert next, a reference-source bit and two power-mode bits.

The converter applies a new channel address only to the conversion that follows, so every reply belongs to the address sent one frame earlier. The controller remembers that address and tags each 12-bit result with the input it really came from. The first reply after reset is tagged as input 0, because the converter's command register starts at zero.

Channels are visited in ascending order, skipping those whose mask bit is clear, and the scan wraps from the highest index back to the lowest. The serial clock comes from a divider of the system clock.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Every frame holds the select low across exactly 16 rising edges of the serial clock.
- R2: The data-out line never changes in the system cycle in which the serial clock rises. It changes only where the serial clock falls, or where the select changes.
- R3: Across the first 8 rising edges the command is sent MSB first. Bits 7 and 6 are 0. Bits 5:3 are the channel address. Bit 2 equals `ref_ext`. Bits 1:0 equal `pwr_mode`. Rising edges 9 to 16 carry 0.
- R4: The channel addresses of successive frames follow ascending order among the channels whose `chan_mask` bit is 1, wrapping from 7 to 0. The first frame after reset requests the lowest enabled channel at or above 0.
- R5: Each result's `result_chan` equals the address sent in the previous frame. The first frame after reset is tagged 0.
- R6: `result_data` equals the last 12 bits received on `adc_miso` in that frame, sampled on the serial clock's rising edges, MSB first. The 4 leading bits are dropped.
- R7: Every frame produces exactly one `result_valid` pulse, one system clock long, after the select returns high.
- R8: Between frames the select stays high for at least one full serial-clock period (2*CLK_DIV system clocks).
- R9: While `enable` is 0 or `chan_mask` is all zeros, no new frame starts. A frame already in progress completes.
- R10: While the select is high, the serial clock rests high and data-out rests low, including straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Permits new frames to start |
| chan_mask | input | 8 | One bit per input; 1 includes that input in the scan |
| ref_ext | input | 1 | Command bit 2: 1 selects an external reference |
| pwr_mode | input | 2 | Command bits 1:0, power mode |
| result_valid | output | 1 | One-cycle strobe for a new result |
| result_data | output | 12 | Conversion value |
| result_chan | output | 3 | Input that produced `result_data` |
| adc_cs_n | output | 1 | Active-low frame select |
| adc_sclk | output | 1 | Serial clock, rests high |
| adc_mosi | output | 1 | Command data to converter |
| adc_miso | input | 1 | Result data from converter |

## Verification
In the same clock, the controller emits the result strobe for the finished frame and hands the remembered address over as that result's tag. Shortly afterwards the scheduler advances and picks the next address, so the tag and the pick depend on each other. The bench models a converter that really applies each address one frame late, and it scores every tag against the address that model actually used. Masks with a single bit, with bits at both ends (forcing a wrap) and random masks are mixed in. The bench also drops `enable` right at a frame boundary, which checks that the last strobe still comes and that nothing more starts.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } frame_state_t;

  localparam int HI_CNT_W = 16;

endpackage

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/adc_scan_sched.sv
module adc_scan_sched #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] mask,
  input  logic              advance,
  output logic [CH_W-1:0]   req_chan
);
  localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] ptr;
  logic [CH_W-1:0] pick;
  logic [CH_W-1:0] cand;
  logic            found;

  // search upward from ptr with wrap; first set mask bit wins
  always_comb begin
    found = 1'b0;
    pick  = ptr;
    cand  = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      cand = CH_W'((int'(ptr) + k) % NUM_CH);
      if (!found && mask[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      req_chan <= '0;
    end else if (advance) begin
      req_chan <= pick;
      ptr      <= (pick == TOP_CH) ? '0 : pick + 1'b1;
    end
  end

  logic [NUM_CH-1:0] mask_d;
  always_ff @(posedge clk) mask_d <= mask;

  // R4
  scan_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && (|mask)) |=> mask_d[req_chan]);
endmodule

// File: rtl/adc_scan_frame.sv
module adc_scan_frame
  import adc_scan_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int FRAME_BITS = 16,
  parameter int CMD_BITS   = 8,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [CMD_BITS-1:0]  cmd,
  input  logic                 miso,
  output logic                 load,
  output logic                 done,
  output logic [DATA_BITS-1:0] rx,
  output logic                 cs_n,
  output logic                 sclk,
  output logic                 mosi
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS);

  frame_state_t        state;
  logic [CNT_W-1:0]    bitcnt;
  logic [CMD_BITS-1:0] tx;
  logic                gap_half;
  logic                tick;
  logic                run;

  assign run  = (state == ST_SHIFT) || (state == ST_GAP);
  assign load = (state == ST_IDLE) && go;

  adc_scan_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      mosi     <= 1'b0;
      done     <= 1'b0;
      bitcnt   <= '0;
      tx       <= '0;
      rx       <= '0;
      gap_half <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) state <= ST_LOAD;
        end
        ST_LOAD: begin
          tx     <= cmd;
          cs_n   <= 1'b0;
          sclk   <= 1'b1;
          mosi   <= cmd[CMD_BITS-1];
          bitcnt <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sclk) begin
              if (bitcnt == LAST_BIT) begin
                cs_n     <= 1'b1;
                mosi     <= 1'b0;
                done     <= 1'b1;
                gap_half <= 1'b0;
                state    <= ST_GAP;
              end else begin
                sclk <= 1'b0;
                if (bitcnt != '0) begin
                  mosi <= tx[CMD_BITS-2];
                  tx   <= {tx[CMD_BITS-2:0], 1'b0};
                end
              end
            end else begin
              sclk   <= 1'b1;
              rx     <= {rx[DATA_BITS-2:0], miso};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            gap_half <= 1'b1;
            if (gap_half) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- checks ----------------
  logic                sclk_d;
  logic [CNT_W:0]      rise_cnt;
  logic [HI_CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b1;
      rise_cnt <= '0;
      hi_cnt   <= '1;
    end else begin
      sclk_d <= sclk;
      if (cs_n)                rise_cnt <= '0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_n)             hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R1
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rise_cnt == (CNT_W+1)'(FRAME_BITS)));

  // R2
  mosi_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));

  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (sclk && !mosi));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= HI_CNT_W'(2 * DIV)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int CLK_DIV    = 4,
  parameter int NUM_CH     = 8,
  parameter int FRAME_BITS = 16,
  parameter int CMD_BITS   = 8,
  parameter int DATA_BITS  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic [NUM_CH-1:0]         chan_mask,
  input  logic                      ref_ext,
  input  logic [1:0]                pwr_mode,
  output logic                      result_valid,
  output logic [DATA_BITS-1:0]      result_data,
  output logic [$clog2(NUM_CH)-1:0] result_chan,
  output logic                      adc_cs_n,
  output logic                      adc_sclk,
  output logic                      adc_mosi,
  input  logic                      adc_miso
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int PAD_W = CMD_BITS - 3 - CH_W;

  logic                 go;
  logic                 load;
  logic                 done;
  logic [DATA_BITS-1:0] rx;
  logic [CH_W-1:0]      req_chan;
  logic [CH_W-1:0]      conv_chan;
  logic                 ref_q;
  logic [1:0]           pm_q;
  logic [CMD_BITS-1:0]  cmd;

  assign go  = enable && (|chan_mask);
  assign cmd = {{PAD_W{1'b0}}, req_chan, ref_q, pm_q};

  adc_scan_sched #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .mask     (chan_mask),
    .advance  (load),
    .req_chan (req_chan)
  );

  adc_scan_frame #(
    .DIV        (CLK_DIV),
    .FRAME_BITS (FRAME_BITS),
    .CMD_BITS   (CMD_BITS),
    .DATA_BITS  (DATA_BITS)
  ) u_frame (
    .clk  (clk),
    .rst  (rst),
    .go   (go),
    .cmd  (cmd),
    .miso (adc_miso),
    .load (load),
    .done (done),
    .rx   (rx),
    .cs_n (adc_cs_n),
    .sclk (adc_sclk),
    .mosi (adc_mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q        <= 1'b0;
      pm_q         <= 2'b00;
      conv_chan    <= '0;
      result_valid <= 1'b0;
      result_data  <= '0;
      result_chan  <= '0;
    end else begin
      result_valid <= 1'b0;
      if (load) begin
        ref_q <= ref_ext;
        pm_q  <= pwr_mode;
      end
      if (done) begin
        result_valid <= 1'b1;
        result_data  <= rx;
        result_chan  <= conv_chan;
        conv_chan    <= req_chan;
      end
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_cs_n && !go) |=> adc_cs_n);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
endmodule

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int WD_LIMIT   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [7:0]  chan_mask = 8'h00;
  logic        ref_ext = 1'b0;
  logic [1:0]  pwr_mode = 2'b00;
  logic        result_valid;
  logic [11:0] result_data;
  logic [2:0]  result_chan;
  logic        adc_cs_n, adc_sclk, adc_mosi;
  logic        adc_miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_ctrl #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .chan_mask(chan_mask),
    .ref_ext(ref_ext), .pwr_mode(pwr_mode),
    .result_valid(result_valid), .result_data(result_data),
    .result_chan(result_chan), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_mosi(adc_mosi), .adc_miso(adc_miso)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [2:0] next_ch(input logic [7:0] m, input logic [2:0] from);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] c;
      c = from + 3'(k);
      if (m[c]) return c;
    end
    return from;
  endfunction

  // converter model and scoreboard
  logic [2:0]  adc_addr = 3'd0;
  logic [2:0]  exp_ptr = 3'd0;
  logic [15:0] word = 16'h0;
  logic [15:0] cmd_sh = 16'h0;
  int          rises = 0;
  int          frames_done = 0;
  int          cs_hi = 1000;
  int          idle_bad = 0;
  int          valids = 0;
  logic        prev_cs = 1'b1, prev_sclk = 1'b1, prev_mosi = 1'b0, prev_valid = 1'b0;
  logic [11:0] q_data[$];
  logic [2:0]  q_chan[$];

  always @(negedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !finished) begin
      chk(1'b0, "watchdog", cyc, WD_LIMIT);
      finish_run();
    end
    if (!rst) begin
      if (prev_cs && !adc_cs_n) begin
        chk(cs_hi >= 2*CLK_DIV, "R8 select gap", cs_hi, 2*CLK_DIV);
        word = 16'($urandom);
        q_data.push_back(word[11:0]);
        q_chan.push_back(adc_addr);
        rises = 0;
        cmd_sh = 16'h0;
        adc_miso = word[15];
      end else if (!adc_cs_n) begin
        if (!prev_sclk && adc_sclk) begin
          chk(adc_mosi == prev_mosi, "R2 data-out stable at rise", adc_mosi, prev_mosi);
          cmd_sh = {cmd_sh[14:0], adc_mosi};
          rises++;
        end else if (prev_sclk && !adc_sclk) begin
          if (rises < 16) adc_miso = word[15-rises];
        end
      end else if (!prev_cs && adc_cs_n) begin
        logic [2:0] e;
        chk(rises == 16, "R1 rising edges per frame", rises, 16);
        chk(cmd_sh[15:14] == 2'b00, "R3 command bits 7:6", cmd_sh[15:14], 0);
        chk(cmd_sh[10] == ref_ext, "R3 reference bit", cmd_sh[10], ref_ext);
        chk(cmd_sh[9:8] == pwr_mode, "R3 power bits", cmd_sh[9:8], pwr_mode);
        chk(cmd_sh[7:0] == 8'h00, "R3 trailing bits low", cmd_sh[7:0], 0);
        e = next_ch(chan_mask, exp_ptr);
        chk(cmd_sh[13:11] == e, "R4 scan order", cmd_sh[13:11], e);
        exp_ptr = e + 3'd1;
        adc_addr = cmd_sh[13:11];
        frames_done++;
        cs_hi = 0;
        adc_miso = 1'b0;
      end
      if (adc_cs_n) begin
        cs_hi++;
        if (!adc_sclk || adc_mosi) idle_bad++;
      end
      if (result_valid) begin
        chk(!prev_valid, "R7 strobe width", prev_valid, 0);
        valids++;
        if (q_data.size() == 0) begin
          chk(1'b0, "R7 strobe without frame", 1, 0);
        end else begin
          logic [11:0] ed;
          logic [2:0]  ec;
          ed = q_data.pop_front();
          ec = q_chan.pop_front();
          chk(result_data == ed, "R6 result value", result_data, ed);
          chk(result_chan == ec, "R5 result tag", result_chan, ec);
        end
      end
    end
    prev_cs = adc_cs_n;
    prev_sclk = adc_sclk;
    prev_mosi = adc_mosi;
    prev_valid = result_valid;
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_phase(input logic [7:0] m, input logic r, input logic [1:0] p, input int n);
    int target;
    chan_mask = m;
    ref_ext = r;
    pwr_mode = p;
    enable = 1'b1;
    target = frames_done + n;
    while (frames_done < target) @(negedge clk);
    enable = 1'b0;
    wait_cycles(300);
    chk(q_data.size() == 0, "R7 one strobe per frame", q_data.size(), 0);
    chk(adc_cs_n == 1'b1, "R9 stopped after enable low", adc_cs_n, 1);
    chk(idle_bad == 0, "R10 idle lines", idle_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_cycles(5);
    rst = 1'b0;
    @(negedge clk);
    chk(adc_cs_n == 1'b1, "R10 reset select", adc_cs_n, 1);
    chk(adc_sclk == 1'b1, "R10 reset clock", adc_sclk, 1);
    chk(adc_mosi == 1'b0, "R10 reset data-out", adc_mosi, 0);
    chk(result_valid == 1'b0, "R7 reset strobe", result_valid, 0);

    // R9: empty mask with enable high, then full mask with enable low
    begin
      int f0;
      f0 = frames_done;
      enable = 1'b1;
      chan_mask = 8'h00;
      wait_cycles(300);
      chk(frames_done == f0, "R9 empty mask idle", frames_done, f0);
      chk(valids == 0, "R9 no strobe on empty mask", valids, 0);
      enable = 1'b0;
      chan_mask = 8'hFF;
      wait_cycles(300);
      chk(frames_done == f0, "R9 enable low idle", frames_done, f0);
    end

    // directed: first frame tagged 0 (R5), single channels, wrap
    run_phase(8'h20, 1'b1, 2'b01, 3);
    run_phase(8'h01, 1'b0, 2'b11, 3);
    run_phase(8'h81, 1'b1, 2'b10, 5);
    run_phase(8'h80, 1'b0, 2'b00, 3);
    run_phase(8'hFF, 1'b1, 2'b11, 10);

    for (int ph = 0; ph < 25; ph++) begin
      logic [7:0] m;
      m = 8'($urandom);
      if (m == 8'h00) m = 8'h10;
      run_phase(m, 1'($urandom), 2'($urandom), 2 + int'($urandom % 8));
    end

    chk(valids == frames_done, "R7 total strobes", valids, frames_done);
    finish_run();
  end
endmodule